// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an up-counter with a small register port for a processor. In timer mode it advances once per clock. In event mode it advances on one chosen edge of an external input. In pulse-width mode it advances on each clock while that input sits at a chosen level. The external input is asynchronous, so it first passes through a two-flop synchronizer and an edge detector. Counts therefore trail the pin by two clocks, and a measured width can be off by one.

When the count passes all ones, the counter reloads from a preload register and keeps running. It also sets an interrupt request flag. The interrupt pin follows that flag only when the interrupt enable bit is set. While the system is powered down, an overflow also raises a wake-up output, whatever the enable bit says, unless the request flag was already pending. Any cycle in which the processor touches the count or control address does not count.

The register port is a plain single-cycle bus. An access is taken in the cycle in which `bus_sel` is high. There is no back-pressure, and read data is combinational from the selected register.

Top module: `tmr_evt_top`

## Requirements
- R1: After reset the count, control and request flag read as zero, and `irq` and `wake` are low.
- R2: Address 0 writes the preload value, and also the count if the enable bit is 0; reading address 0 returns the live count. Address 1 is control: bit 0 enable, bits 2:1 mode (00 stopped, 01 event, 10 timer, 11 pulse width), bit 3 polarity, bit 4 interrupt enable. Address 2 bit 0 is the request flag; a write stores that bit, so 1 sets it and 0 clears it.
- R3: In timer mode with enable set, the count rises by one on each clock edge that is not inhibited.
- R4: A cycle with `bus_sel` high and address 0 or 1 does not advance the count. An access to address 2 does not hold counting.
- R5: An advance from all ones loads the preload value, sets the request flag, and counting carries on.
- R6: In event mode the count rises once per synchronized edge of `ext_in`: rising when polarity is 0, falling when polarity is 1. The other edge has no effect.
- R7: In pulse-width mode the count rises on each clock whose synchronized `ext_in` equals the selected level: high for polarity 0, low for polarity 1.
- R8: With mode 00, or with enable clear, the count holds whatever `ext_in` does.
- R9: The flag is set by an overflow whether or not the interrupt is enabled. `irq` is high exactly when both the flag and the interrupt enable are set.
- R10: A write of 0 to the flag in the same cycle as an overflow leaves the flag set.
- R11: An overflow while `pwr_down` is high and the flag is clear raises `wake`. `wake` stays high until the clock after `pwr_down` falls, and it is never raised while `pwr_down` is low.
- R12: An overflow while the flag is already set does not raise `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register |
| ext_in | input | 1 | Asynchronous external count/gate input |
| pwr_down | input | 1 | System is in power-down |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench reads the count twice in a row. A design that kept counting through a register access would return two different values. It issues a flag clear in the exact cycle the counter wraps, so a design that gives the clear priority would lose the request. It drives the input for counted windows in both pulse-width polarities, and pulses it under each edge polarity, so a design that mixes up the polarity or miscounts the synchronizer latency would show an off count. For wake-up, it triggers an overflow in power-down once with the flag clear and once with the flag set. A design that wakes regardless of the pending flag, or that never drops the wake output, would show it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_EVT  = 2'b01,
    MODE_TMR  = 2'b10,
    MODE_PW   = 2'b11
  } tmr_mode_e;

  // packed LSB-last: {ie, pol, mode, en} maps to bits 4,3,2:1,0
  typedef struct packed {
    logic      ie;
    logic      pol;
    tmr_mode_e mode;
    logic      en;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);
  localparam logic [1:0] ADR_CNT = 2'd0;
  localparam logic [1:0] ADR_CTL = 2'd1;
  localparam logic [1:0] ADR_STS = 2'd2;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             ovf,
  input  logic             pwr_down,
  output tmr_ctl_t         ctl,
  output logic [CNT_W-1:0] preload,
  output logic             flag,
  output logic             wake,
  output logic             inhibit,
  output logic             load_cnt
);
  logic wr_cnt, wr_ctl, wr_sts;

  assign wr_cnt   = bus_sel & bus_wr & (bus_addr == ADR_CNT);
  assign wr_ctl   = bus_sel & bus_wr & (bus_addr == ADR_CTL);
  assign wr_sts   = bus_sel & bus_wr & (bus_addr == ADR_STS);
  assign inhibit  = bus_sel & ((bus_addr == ADR_CNT) | (bus_addr == ADR_CTL));
  assign load_cnt = wr_cnt & ~ctl.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      preload <= '0;
      flag    <= 1'b0;
      wake    <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= tmr_ctl_t'(bus_wdata[CTL_W-1:0]);
      if (wr_cnt) preload <= bus_wdata;
      // overflow outranks a software write to the flag
      if (ovf)         flag <= 1'b1;
      else if (wr_sts) flag <= bus_wdata[0];
      if (!pwr_down)          wake <= 1'b0;
      else if (ovf && !flag)  wake <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  tmr_mode_e        mode,
  input  logic             pol,
  input  logic             inhibit,
  input  logic             load_cnt,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preload,
  input  logic             ext_lvl,
  input  logic             ext_rise,
  input  logic             ext_fall,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic step, adv;

  always_comb begin
    unique case (mode)
      MODE_EVT: step = pol ? ext_fall : ext_rise;
      MODE_TMR: step = 1'b1;
      MODE_PW:  step = (ext_lvl == ~pol);
      default:  step = 1'b0;
    endcase
  end

  assign adv = en & ~inhibit & step;
  assign ovf = adv & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load_cnt) cnt <= load_val;
    else if (adv)      cnt <= ovf ? preload : cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_in,
  input  logic             pwr_down,
  output logic             irq,
  output logic             wake
);
  tmr_ctl_t         ctl_q;
  logic [CNT_W-1:0] preload_q, cnt_q;
  logic             flag_q, ovf, inhibit, load_cnt;
  logic             ext_lvl, ext_rise, ext_fall;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in),
    .lvl(ext_lvl), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ovf(ovf),
    .pwr_down(pwr_down), .ctl(ctl_q), .preload(preload_q),
    .flag(flag_q), .wake(wake), .inhibit(inhibit), .load_cnt(load_cnt)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .mode(ctl_q.mode),
    .pol(ctl_q.pol), .inhibit(inhibit), .load_cnt(load_cnt),
    .load_val(bus_wdata), .preload(preload_q), .ext_lvl(ext_lvl),
    .ext_rise(ext_rise), .ext_fall(ext_fall), .cnt(cnt_q), .ovf(ovf)
  );

  always_comb begin
    unique case (bus_addr)
      ADR_CNT: bus_rdata = cnt_q;
      ADR_CTL: bus_rdata = CNT_W'(ctl_q);
      ADR_STS: bus_rdata = {{(CNT_W-1){1'b0}}, flag_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & ctl_q.ie;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] cnt,
  input logic             en,
  input logic [1:0]       mode,
  input logic             ovf,
  input logic             flag,
  input logic             wake,
  input logic             pwr_down
);
  // R4
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_addr == 2'd1 || (bus_addr == 2'd0 && !bus_wr))) |=> $stable(cnt));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && (!en || mode == 2'b00)) |=> $stable(cnt));

  // R5
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);

  // R11
  wake_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |=> !wake);

  // R12
  wake_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> (!$past(flag) && $past(pwr_down) && $past(ovf)));
endmodule

bind tmr_evt_top tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .cnt(cnt_q), .en(ctl_q.en), .mode(ctl_q.mode),
  .ovf(ovf), .flag(flag_q), .wake(wake), .pwr_down(pwr_down)
);

// File: tb/tb_tmr_evt_top.sv
`timescale 1ns/1ps
module tb_tmr_evt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0, pwr_down = 1'b0;
  logic       irq, wake;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  tmr_evt_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .pwr_down(pwr_down), .irq(irq), .wake(wake)
  );

  // control word builder: {ie, pol, mode[1:0], en}
  function automatic logic [7:0] ctlw(bit en, logic [1:0] md, bit pol, bit ie);
    return {3'b000, ie, pol, md, en};
  endfunction

  // monitor: compares every read against the scoreboard
  always begin
    @(negedge clk);
    #2;
    if (bus_sel && !bus_wr) begin
      sb_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %0h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: read actual %0h expected %0h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic set_ext(input logic v);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ext_in = v;
  endtask

  task automatic set_pd(input logic v);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; pwr_down = v;
  endtask

  task automatic pulse();
    set_ext(1'b1); idle(3); set_ext(1'b0); idle(3);
  endtask

  // which: 0 = irq, 1 = wake
  task automatic pin_chk(input int which, input logic e, input string tag);
    logic a;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #2;
    a = (which == 0) ? irq : wake;
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: %s actual %b expected %b", tag,
               (which == 0) ? "irq" : "wake", a, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    pin_chk(0, 1'b0, "R1");
    pin_chk(1, 1'b0, "R1");
    rd(2'd0, 8'h00, "R1");
    rd(2'd1, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1");

    // R2 R3 timer mode
    wr(2'd0, 8'hF0);
    wr(2'd1, ctlw(1, 2'b10, 0, 0));
    rd(2'd1, ctlw(1, 2'b10, 0, 0), "R2");
    idle(5);
    rd(2'd0, 8'hF5, "R3");
    rd(2'd0, 8'hF5, "R4");   // previous read held the count
    idle(2);
    rd(2'd0, 8'hF7, "R3");
    idle(9);                 // 8 steps to FF, 9th wraps to preload
    rd(2'd0, 8'hF0, "R5");
    rd(2'd2, 8'h01, "R5");   // status read does not hold counting: F1
    pin_chk(0, 1'b0, "R9");  // F2
    wr(2'd1, ctlw(1, 2'b10, 0, 1));
    pin_chk(0, 1'b1, "R9");  // F3
    wr(2'd2, 8'h00);         // F4
    pin_chk(0, 1'b0, "R9");  // F5
    rd(2'd0, 8'hF5, "R4");

    // R10 clear collides with overflow
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFD);
    wr(2'd2, 8'h01);
    wr(2'd1, ctlw(1, 2'b10, 0, 0));
    idle(2);                 // FE, FF
    wr(2'd2, 8'h00);         // overflow in this cycle
    rd(2'd2, 8'h01, "R10");
    wr(2'd1, 8'h00);
    rd(2'd0, 8'hFE, "R10");

    // R6 event counting
    wr(2'd0, 8'h10);
    wr(2'd1, ctlw(1, 2'b01, 0, 0));
    pulse(); pulse(); pulse();
    rd(2'd0, 8'h13, "R6");
    wr(2'd1, ctlw(1, 2'b01, 1, 0));
    pulse(); pulse();
    rd(2'd0, 8'h15, "R6");

    // R8 stopped mode and disabled timer
    wr(2'd1, ctlw(1, 2'b00, 0, 0));
    pulse(); idle(3);
    rd(2'd0, 8'h15, "R8");
    wr(2'd1, ctlw(0, 2'b10, 0, 0));
    idle(4);
    rd(2'd0, 8'h15, "R8");

    // R7 pulse width, high level
    wr(2'd0, 8'h00);
    wr(2'd1, ctlw(1, 2'b11, 0, 0));
    idle(4);
    set_ext(1'b1); idle(5); set_ext(1'b0); idle(4);
    rd(2'd0, 8'h06, "R7");
    // R7 pulse width, low level
    wr(2'd1, 8'h00);
    set_ext(1'b1); idle(3);
    wr(2'd1, ctlw(1, 2'b11, 1, 0));
    idle(3);
    set_ext(1'b0); idle(3); set_ext(1'b1); idle(4);
    rd(2'd0, 8'h0A, "R7");

    // R11 wake on overflow in power-down
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFE);
    set_pd(1'b1);
    wr(2'd1, ctlw(1, 2'b10, 0, 0));
    idle(2);
    pin_chk(1, 1'b1, "R11");
    pin_chk(0, 1'b0, "R9");
    rd(2'd2, 8'h01, "R11");
    set_pd(1'b0);
    pin_chk(1, 1'b0, "R11");

    // R12 pending flag suppresses wake
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h01, "R2");
    wr(2'd0, 8'hFE);
    set_pd(1'b1);
    wr(2'd1, ctlw(1, 2'b10, 0, 0));
    idle(2);
    pin_chk(1, 1'b0, "R12");
    pin_chk(1, 1'b0, "R12");
    set_pd(1'b0);
    idle(3);

    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule